// File: doc/BRIEF.md
# Memory Request Intake Queue

This block is the user-side entry point of a DRAM controller. A requester presents read or write requests with a flat local address, a burst length counted in local words, byte enables and write data. Each accepted request is split into chip, bank, row and column fields and stored as one command in a small in-order queue, which the downstream command scheduler drains. Write data beats go into a separate data FIFO, and each stored command records where its first beat sits there.

Back-pressure comes from a single ready output that follows the occupancy of both FIFOs. A write of N beats occupies the interface for N accepted cycles, one beat per cycle. A parameter selects half-rate column scaling, where each local column step becomes four memory columns.

Top module: `mc_req_queue`

## Requirements
- R1: A request is taken only on a rising clock edge where req_ready is high together with req_rd or req_wr. A request held while req_ready is low adds no command.
- R2: Once a request is accepted, a new request presented in the next cycle is accepted at once if space allows. Consecutive reads therefore enter one per cycle.
- R3: req_ready is low whenever the command queue holds CMD_DEPTH entries and no write burst is in progress. It returns high in the cycle after the scheduler pops an entry.
- R4: The local address is split from its least significant end as column (CW bits), bank (BKW), row (RW), then chip (CSW). With HALF_RATE=1 the memory column is the local column shifted left by two, so local column 2 gives 8 and local column 3 gives 0xC.
- R5: Local address 0 gives chip 0, bank 0, row 0 and memory column 0.
- R6: A write with size N (N at least 1) is accepted over N cycles, with req_ready held high after the first beat. It produces exactly one command (cmd_is_wr=1, cmd_size=N) and N data entries, kept in beat order with their byte enables. cmd_wptr is the data FIFO slot of the first beat.
- R7: A new write is refused (req_ready low) while the data FIFO has fewer than req_size free slots, even if the command queue has room.
- R8: A read takes one command slot and no data FIFO slot (cmd_is_wr=0). The write that follows it gets the data slot right after the previous write's last beat.
- R9: Reset empties both FIFOs. req_ready stays low until the second rising edge after reset is released.
- R10: Commands leave the queue in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request, one cycle per data beat |
| req_addr | input | CW+BKW+RW+CSW | Local word address |
| req_size | input | SW | Burst length in local words |
| req_be | input | DW/8 | Byte enables of the current write beat |
| req_wdata | input | DW | Current write beat |
| req_ready | output | 1 | Request can be taken this cycle |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_pop | input | 1 | Scheduler removes the head command |
| cmd_is_wr | output | 1 | Head command is a write (1) or read (0) |
| cmd_chip | output | CSW | Head chip select index |
| cmd_bank | output | BKW | Head bank |
| cmd_row | output | RW | Head row |
| cmd_col | output | CW+2*HALF_RATE | Head memory column |
| cmd_size | output | SW | Head burst length |
| cmd_wptr | output | log2(WD_DEPTH) | Data FIFO slot of the head write's first beat |
| wd_valid | output | 1 | Data FIFO not empty |
| wd_pop | input | 1 | Scheduler removes the head data beat |
| wd_data | output | DW | Head data beat |
| wd_be | output | DW/8 | Head byte enables |

## Verification
The hardest case to reach is a refusal caused only by the data FIFO, with free command slots but too few data slots for a new write. The bench gets there by queuing two four-beat writes that fill the eight-entry data FIFO while only two commands are stored. It then holds a one-beat write and pops a single data beat, so req_ready should rise. A queue-full stall is reached with four back-to-back reads. A fifth read is held for several cycles, and the drained command stream shows whether it entered exactly once.

// File: rtl/mc_req_pkg.sv
package mc_req_pkg;
   // command direction as stored in the queue
   typedef enum logic {MC_OP_RD = 1'b0, MC_OP_WR = 1'b1} mc_op_e;
   // column scaling applied in half-rate operation
   localparam int unsigned MC_HR_SHIFT = 2;
endpackage

// File: rtl/mc_sync_fifo.sv
module mc_sync_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH):0]     count,
   output logic [$clog2(DEPTH)-1:0]   wr_idx
);
   localparam int unsigned IW   = $clog2(DEPTH);
   localparam int unsigned CNTW = IW + 1;

   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("mc_sync_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]    mem [DEPTH];
   logic [IW-1:0]   wp, rp;
   logic [CNTW-1:0] cnt;
   logic            do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == CNTW'(DEPTH));
   assign count   = cnt;
   assign wr_idx  = wp;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CNTW'(do_push) - CNTW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/mc_addr_map.sv
module mc_addr_map #(
   parameter int unsigned CW        = 8,
   parameter int unsigned BKW       = 3,
   parameter int unsigned RW        = 13,
   parameter int unsigned CSW       = 1,
   parameter bit          HALF_RATE = 1'b1
) (
   input  logic [CW+BKW+RW+CSW-1:0]                         addr,
   output logic [CSW-1:0]                                   chip,
   output logic [BKW-1:0]                                   bank,
   output logic [RW-1:0]                                    row,
   output logic [CW+(HALF_RATE ? mc_req_pkg::MC_HR_SHIFT : 0)-1:0] col
);
   import mc_req_pkg::*;

   localparam int unsigned BK_LSB = CW;
   localparam int unsigned RW_LSB = CW + BKW;
   localparam int unsigned CS_LSB = CW + BKW + RW;

   assign bank = addr[BK_LSB +: BKW];
   assign row  = addr[RW_LSB +: RW];
   assign chip = addr[CS_LSB +: CSW];

   if (HALF_RATE) begin : g_half_rate
      assign col = {addr[CW-1:0], {MC_HR_SHIFT{1'b0}}};
   end else begin : g_full_rate
      assign col = addr[CW-1:0];
   end
endmodule

// File: rtl/mc_req_queue.sv
module mc_req_queue #(
   parameter int unsigned CW        = 8,
   parameter int unsigned BKW       = 3,
   parameter int unsigned RW        = 13,
   parameter int unsigned CSW       = 1,
   parameter bit          HALF_RATE = 1'b1,
   parameter int unsigned SW        = 3,
   parameter int unsigned DW        = 32,
   parameter int unsigned CMD_DEPTH = 4,
   parameter int unsigned WD_DEPTH  = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_rd,
   input  logic                                   req_wr,
   input  logic [CW+BKW+RW+CSW-1:0]               req_addr,
   input  logic [SW-1:0]                          req_size,
   input  logic [DW/8-1:0]                        req_be,
   input  logic [DW-1:0]                          req_wdata,
   output logic                                   req_ready,
   output logic                                   cmd_valid,
   input  logic                                   cmd_pop,
   output logic                                   cmd_is_wr,
   output logic [CSW-1:0]                         cmd_chip,
   output logic [BKW-1:0]                         cmd_bank,
   output logic [RW-1:0]                          cmd_row,
   output logic [CW+(HALF_RATE ? 2 : 0)-1:0]      cmd_col,
   output logic [SW-1:0]                          cmd_size,
   output logic [$clog2(WD_DEPTH)-1:0]            cmd_wptr,
   output logic                                   wd_valid,
   input  logic                                   wd_pop,
   output logic [DW-1:0]                          wd_data,
   output logic [DW/8-1:0]                        wd_be
);
   import mc_req_pkg::*;

   localparam int unsigned BEW   = DW / 8;
   localparam int unsigned MCW   = CW + (HALF_RATE ? MC_HR_SHIFT : 0);
   localparam int unsigned WPW   = $clog2(WD_DEPTH);
   localparam int unsigned CCW   = $clog2(CMD_DEPTH) + 1;
   localparam int unsigned WCW   = WPW + 1;
   localparam int unsigned CMD_W = 1 + CSW + BKW + RW + MCW + SW + WPW;
   localparam int unsigned WD_W  = DW + BEW;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("mc_req_queue: DW must be a multiple of 8");
   end
   if (((1 << SW) - 1) > WD_DEPTH) begin : g_bad_wd
      $error("mc_req_queue: WD_DEPTH must hold the largest burst");
   end

   // address split
   logic [CSW-1:0] m_chip;
   logic [BKW-1:0] m_bank;
   logic [RW-1:0]  m_row;
   logic [MCW-1:0] m_col;

   mc_addr_map #(
      .CW(CW), .BKW(BKW), .RW(RW), .CSW(CSW), .HALF_RATE(HALF_RATE)
   ) u_map (
      .addr(req_addr), .chip(m_chip), .bank(m_bank), .row(m_row), .col(m_col)
   );

   // acceptance control
   logic          init_q1, init_q2;
   logic [SW-1:0] beats_left;
   logic          bursting;
   logic          new_acc, cmd_push, wd_push;
   logic          cmd_full, cmd_empty, wd_full, wd_empty;
   logic [CCW-1:0] cmd_cnt;
   logic [WCW-1:0] wd_cnt;
   logic [WPW-1:0] wd_widx;
   logic          space_ok;
   mc_op_e        op;

   assign bursting = (beats_left != '0);
   assign space_ok = (int'(req_size) <= int'(WD_DEPTH) - int'(wd_cnt));
   assign op       = req_wr ? MC_OP_WR : MC_OP_RD;

   always_comb begin
      if (!init_q2)      req_ready = 1'b0;
      else if (bursting) req_ready = 1'b1;
      else if (cmd_full) req_ready = 1'b0;
      else if (req_wr)   req_ready = space_ok;
      else               req_ready = 1'b1;
   end

   assign new_acc  = req_ready && !bursting && (req_rd || req_wr);
   assign cmd_push = new_acc;
   assign wd_push  = req_ready && req_wr && (bursting || new_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q1    <= 1'b0;
         init_q2    <= 1'b0;
         beats_left <= '0;
      end else begin
         init_q1 <= 1'b1;
         init_q2 <= init_q1;
         if (new_acc && req_wr)
            beats_left <= (req_size == '0) ? '0 : req_size - 1'b1;
         else if (bursting && req_wr)
            beats_left <= beats_left - 1'b1;
      end
   end

   // command queue
   logic [CMD_W-1:0] cmd_din, cmd_dout;
   logic [WPW-1:0]   unused_cidx;

   assign cmd_din = {op, m_chip, m_bank, m_row, m_col, req_size, wd_widx};

   mc_sync_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
      .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_din),
      .pop(cmd_pop), .dout(cmd_dout), .empty(cmd_empty), .full(cmd_full),
      .count(cmd_cnt), .wr_idx(unused_cidx[$clog2(CMD_DEPTH)-1:0])
   );
   if (WPW > $clog2(CMD_DEPTH)) begin : g_pad_idx
      assign unused_cidx[WPW-1:$clog2(CMD_DEPTH)] = '0;
   end

   assign cmd_valid = !cmd_empty;
   assign {cmd_is_wr, cmd_chip, cmd_bank, cmd_row, cmd_col, cmd_size, cmd_wptr} = cmd_dout;

   // write data FIFO
   logic [WD_W-1:0] wd_dout;

   mc_sync_fifo #(.W(WD_W), .DEPTH(WD_DEPTH)) u_wdq (
      .clk(clk), .rst_n(rst_n), .push(wd_push), .din({req_be, req_wdata}),
      .pop(wd_pop), .dout(wd_dout), .empty(wd_empty), .full(wd_full),
      .count(wd_cnt), .wr_idx(wd_widx)
   );

   assign wd_valid         = !wd_empty;
   assign {wd_be, wd_data} = wd_dout;
endmodule

// File: rtl/mc_req_queue_chk.sv
module mc_req_queue_chk #(
   parameter int unsigned CMD_DEPTH = 4,
   parameter int unsigned WD_DEPTH  = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_rd,
   input logic                         req_wr,
   input logic                         req_ready,
   input logic                         cmd_pop,
   input logic                         wd_pop,
   input logic                         bursting,
   input logic [$clog2(CMD_DEPTH):0]   cmd_cnt,
   input logic [$clog2(WD_DEPTH):0]    wd_cnt
);
   localparam int unsigned CCW = $clog2(CMD_DEPTH) + 1;
   localparam int unsigned WCW = $clog2(WD_DEPTH) + 1;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_cnt <= CCW'(CMD_DEPTH) && wd_cnt <= WCW'(WD_DEPTH)); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_cnt == CCW'(CMD_DEPTH) && !bursting) |-> !req_ready); // R3

   AST_CMD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !bursting && (req_rd || req_wr) && !cmd_pop)
      |=> cmd_cnt == $past(cmd_cnt) + CCW'(1)); // R1

   AST_BEAT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_wr && !wd_pop) |=> wd_cnt == $past(wd_cnt) + WCW'(1)); // R6

   AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_rd && !req_wr && !bursting && !wd_pop) |=> $stable(wd_cnt)); // R8

   AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !req_ready); // R9
endmodule

bind mc_req_queue mc_req_queue_chk #(.CMD_DEPTH(CMD_DEPTH), .WD_DEPTH(WD_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
   .req_ready(req_ready), .cmd_pop(cmd_pop), .wd_pop(wd_pop),
   .bursting(bursting), .cmd_cnt(cmd_cnt), .wd_cnt(wd_cnt)
);

// File: tb/mc_req_queue_bench.sv
module mc_req_queue_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0, req_wr = 1'b0;
   logic [24:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, cmd_valid, cmd_is_wr, wd_valid;
   logic        cmd_pop = 1'b0, wd_pop = 1'b0;
   logic [0:0]  cmd_chip;
   logic [2:0]  cmd_bank;
   logic [12:0] cmd_row;
   logic [9:0]  cmd_col;
   logic [2:0]  cmd_size, cmd_wptr;
   logic [31:0] wd_data;
   logic [3:0]  wd_be;

   int checks = 0, fails = 0;
   int model_widx = 0;
   bit done = 0;

   always #10 clk = ~clk;

   mc_req_queue u_mc_req_queue (
      .clk, .rst_n, .req_rd, .req_wr, .req_addr, .req_size, .req_be, .req_wdata,
      .req_ready, .cmd_valid, .cmd_pop, .cmd_is_wr, .cmd_chip, .cmd_bank,
      .cmd_row, .cmd_col, .cmd_size, .cmd_wptr, .wd_valid, .wd_pop, .wd_data, .wd_be
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [24:0] mk_addr(input int chip, input int row, input int bank, input int col);
      return {chip[0], row[12:0], bank[2:0], col[7:0]};
   endfunction

   task automatic send(input bit wr, input logic [24:0] a, input int size, input logic [31:0] dbase);
      int n = wr ? size : 1;
      for (int b = 0; b < n; b++) begin
         int guard = 0;
         req_rd = !wr; req_wr = wr; req_addr = a; req_size = size[2:0];
         req_be = 4'hF ^ b[3:0]; req_wdata = dbase + b;
         #1;
         if (b > 0) chk(req_ready == 1'b1, "R6 ready held in burst", 32'(req_ready), 1);
         while (!req_ready && guard < 50) begin @(negedge clk); #1; guard++; end
         @(negedge clk);
      end
      req_rd = 0; req_wr = 0;
      if (wr) model_widx += size;
   endtask

   task automatic pop_cmd();
      cmd_pop = 1; @(negedge clk); cmd_pop = 0; #1;
   endtask

   task automatic take_wd(input logic [31:0] ed, input logic [3:0] eb, input string req);
      chk(wd_valid && wd_data == ed, req, wd_data, ed);
      chk(wd_be == eb, req, 32'(wd_be), 32'(eb));
      wd_pop = 1; @(negedge clk); wd_pop = 0; #1;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(!req_ready && !cmd_valid && !wd_valid, "R9 reset state", {req_ready, cmd_valid, wd_valid}, 0);
      rst_n = 1;
      @(negedge clk); #1;
      chk(req_ready == 0, "R9 ready low after release", 32'(req_ready), 0);
      @(negedge clk); #1;
      chk(req_ready == 1, "R9 ready up", 32'(req_ready), 1);
   endtask

   task automatic t_map();
      send(0, mk_addr(1, 'h123, 5, 3), 2, 0); #1;
      chk(cmd_valid && cmd_is_wr == 0, "R8 read command", 32'(cmd_is_wr), 0);
      chk(cmd_chip == 1 && cmd_bank == 5 && cmd_row == 'h123, "R4 chip/bank/row",
          {cmd_chip, cmd_bank, cmd_row}, {1'b1, 3'd5, 13'h123});
      chk(cmd_col == 'hC, "R4 col 3 to 0xC", 32'(cmd_col), 'hC);
      pop_cmd();
      send(0, mk_addr(0, 0, 0, 2), 1, 0); #1;
      chk(cmd_col == 8, "R4 col 2 to 8", 32'(cmd_col), 8);
      pop_cmd();
      send(0, 25'd0, 1, 0); #1;
      chk({cmd_chip, cmd_bank, cmd_row, cmd_col} == 0, "R5 address zero",
          {cmd_chip, cmd_bank, cmd_row, cmd_col}, 0);
      pop_cmd();
      chk(!cmd_valid, "R1 queue empty", 32'(cmd_valid), 0);
   endtask

   task automatic t_fill();
      int cols[5] = '{0, 1, 2, 3, 9};
      for (int k = 0; k < 4; k++) begin
         req_rd = 1; req_addr = mk_addr(0, 0, 0, cols[k]); req_size = 1; #1;
         chk(req_ready == 1, "R2 back-to-back accept", 32'(req_ready), 1);
         @(negedge clk);
      end
      req_addr = mk_addr(0, 0, 0, 9); #1;
      chk(req_ready == 0, "R3 full stalls", 32'(req_ready), 0);
      repeat (3) @(negedge clk);
      #1;
      chk(req_ready == 0, "R1 held while not ready", 32'(req_ready), 0);
      cmd_pop = 1; @(negedge clk); cmd_pop = 0; #1;
      chk(req_ready == 1, "R3 ready after pop", 32'(req_ready), 1);
      @(negedge clk); req_rd = 0; #1;
      for (int k = 1; k < 5; k++) begin
         chk(cmd_valid && cmd_col == 10'(cols[k] << 2), "R10 order", 32'(cmd_col), cols[k] << 2);
         pop_cmd();
      end
      chk(!cmd_valid, "R1 stalled request entered once", 32'(cmd_valid), 0);
   endtask

   task automatic t_write();
      int p = model_widx % 8;
      send(1, mk_addr(0, 4, 2, 7), 2, 32'hA000); #1;
      chk(cmd_valid && cmd_is_wr && cmd_size == 2, "R6 one write cmd", {cmd_is_wr, cmd_size}, {1'b1, 3'd2});
      chk(cmd_wptr == 3'(p), "R6 data pointer", 32'(cmd_wptr), p);
      chk(cmd_col == 'h1C, "R4 write col", 32'(cmd_col), 'h1C);
      take_wd(32'hA000, 4'hF, "R6 beat 0");
      take_wd(32'hA001, 4'hE, "R6 beat 1");
      chk(!wd_valid, "R6 exactly two beats", 32'(wd_valid), 0);
      pop_cmd();
      chk(!cmd_valid, "R6 single command", 32'(cmd_valid), 0);
      p = model_widx % 8;
      send(1, 25'd1, 1, 32'hB000);
      send(0, 25'd2, 1, 0);
      send(1, 25'd3, 1, 32'hB100); #1;
      chk(cmd_wptr == 3'(p), "R8 first write ptr", 32'(cmd_wptr), p);
      pop_cmd();
      chk(cmd_is_wr == 0, "R8 read between", 32'(cmd_is_wr), 0);
      pop_cmd();
      chk(cmd_wptr == 3'((p + 1) % 8), "R8 read used no data slot", 32'(cmd_wptr), (p + 1) % 8);
      pop_cmd();
      take_wd(32'hB000, 4'hF, "R8 data 0");
      take_wd(32'hB100, 4'hF, "R8 data 1");
      chk(!wd_valid, "R8 no read data entry", 32'(wd_valid), 0);
   endtask

   task automatic t_dfull();
      send(1, 25'd16, 4, 32'hC000);
      send(1, 25'd20, 4, 32'hD000);
      req_wr = 1; req_addr = 25'd24; req_size = 1; req_be = 4'h5; req_wdata = 32'hE000; #1;
      chk(req_ready == 0, "R7 data FIFO full refuses", 32'(req_ready), 0);
      @(negedge clk); #1;
      chk(req_ready == 0, "R7 still refused", 32'(req_ready), 0);
      take_wd(32'hC000, 4'hF, "R7 first beat out");
      chk(req_ready == 1, "R7 ready after data pop", 32'(req_ready), 1);
      @(negedge clk); req_wr = 0; model_widx += 1; #1;
      for (int k = 1; k < 4; k++) take_wd(32'hC000 + k, 4'hF ^ 4'(k), "R6 burst A order");
      for (int k = 0; k < 4; k++) take_wd(32'hD000 + k, 4'hF ^ 4'(k), "R6 burst B order");
      take_wd(32'hE000, 4'h5, "R7 late write data");
      for (int k = 0; k < 3; k++) pop_cmd();
      chk(!cmd_valid && !wd_valid, "R10 drained", {cmd_valid, wd_valid}, 0);
   endtask

   initial begin
      t_reset();
      t_map();
      t_fill();
      t_write();
      t_dfull();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule